// File: doc/BRIEF.md
# CIC Interpolation Filter

This block raises the sample rate of a signed stream by an integer factor R and needs no multipliers and no coefficient storage. A chain of N difference stages, each with a lag of M low-rate samples, runs once per low-rate period. Its result feeds a zero-stuffing register that carries the new value for one high-rate cycle and zero for the other R-1 cycles. N running-sum stages then operate on every high-rate cycle. Together they smooth out the spectral images that zero insertion creates.

The upstream source offers a sample with a valid/data pair. The block takes it only on the cycle in which it raises its ready output, and ready is high on one cycle in every R. The output produces a new sample on every clock once reset is released. The block applies no gain normalisation and no rounding. The internal width is grown so that the full filter gain fits, and all arithmetic wraps in two's complement.

Top module: `cic_interp`

## Requirements
- R1: While rst_n is low, out_data is 0 and out_valid is 0. On the first cycle after reset is released, in_ready is 1.
- R2: in_ready is high on exactly one cycle in every R, starting with the first cycle after reset, and stays low on the other R-1 cycles.
- R3: When in_ready is low, in_valid and in_data have no effect on out_data.
- R4: out_valid is 1 on every cycle after the first rising edge that follows reset release.
- R5: out_data is the two's-complement, W-bit result, taken modulo 2^W, of three steps in order. First, take the N-fold lag-M difference of the accepted low-rate stream. Second, zero-stuff it by R. Third, take an N-fold running sum at the high rate. W = IN_W + ceil(log2((R*M)^N)).
- R6: A constant accepted input x settles to x*(R*M)^N/R at the output.
- R7: When in_valid is low on a ready cycle, the block takes a zero-valued sample in its place.
- R8: A sample accepted at one rising edge first shows at out_data after N+1 rising edges, counting the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input sample offered |
| in_data | input | IN_W | Signed input sample |
| in_ready | output | 1 | Block takes a sample on this cycle |
| out_valid | output | 1 | Output sample valid (every cycle after reset) |
| out_data | output | W | Signed high-rate output sample |

## Verification
The bench feeds garbage on the non-ready cycles. A design that latched input outside the ready phase would show a non-zero output where zero is expected. An impulse is placed against a latency count, so that one register too many or too few in the stage chain moves the first non-zero output. The bench holds constants of both signs, and a wrong lag, a wrong stage count or a missing zero-fill would then settle away from x*(R*M)^N/R. Missing samples on ready cycles must act as zeros, and a reset in mid-stream must clear every difference history and running sum, or the output that follows drifts from the reference.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Bits of growth needed to hold the full (R*M)^N gain
  function automatic int cic_growth(input int n, input int r, input int m);
    longint prod;
    prod = 1;
    for (int i = 0; i < n; i++) prod = prod * longint'(r * m);
    return $clog2(prod);
  endfunction
endpackage

// File: rtl/cic_phase_ctr.sv
module cic_phase_ctr #(
  parameter int R = 8,
  localparam int PW = (R > 1) ? $clog2(R) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    if (ph_q == PW'(R - 1)) ph_d = '0;
    else                    ph_d = ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign tick = (ph_q == '0);
endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
  parameter int W = 21,
  parameter int M = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] hist_q [M];
  logic [W-1:0] hist_d [M];

  always_comb begin
    hist_d = hist_q;
    if (en) begin
      hist_d[0] = din;
      for (int i = 1; i < M; i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < M; i++) hist_q[i] <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // difference against the sample M low-rate periods back
  assign dout = din - hist_q[M-1];
endmodule

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign dout = acc_q;
endmodule

// File: rtl/cic_interp.sv
module cic_interp #(
  parameter int IN_W = 12,
  parameter int N    = 3,
  parameter int R    = 8,
  parameter int M    = 1,
  localparam int W   = IN_W + cic_pkg::cic_growth(N, R, M)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [W-1:0]    out_data
);
  logic         tick;
  logic [W-1:0] comb_w  [N+1];
  logic [W-1:0] integ_w [N+1];
  logic [W-1:0] up_q, up_d;
  logic         ov_q, ov_d;

  cic_phase_ctr #(.R(R)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  // sign-extended sample, zero when nothing is offered
  always_comb begin
    if (in_valid) comb_w[0] = {{(W-IN_W){in_data[IN_W-1]}}, in_data};
    else          comb_w[0] = '0;
  end

  for (genvar k = 0; k < N; k++) begin : g_comb
    cic_comb_stage #(.W(W), .M(M)) u_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tick),
      .din  (comb_w[k]),
      .dout (comb_w[k+1])
    );
  end

  // zero-stuffing register
  always_comb begin
    if (tick) up_d = comb_w[N];
    else      up_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= '0;
    else        up_q <= up_d;
  end

  assign integ_w[0] = up_q;

  for (genvar k = 0; k < N; k++) begin : g_integ
    cic_integ_stage #(.W(W)) u_integ (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (1'b1),
      .din  (integ_w[k]),
      .dout (integ_w[k+1])
    );
  end

  assign ov_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  assign in_ready  = tick;
  assign out_valid = ov_q;
  assign out_data  = integ_w[N];
endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk #(
  parameter int R = 8,
  parameter int W = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] zfill
);
  int gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= 0;
    else if (in_ready) gap_q <= 0;
    else               gap_q <= gap_q + 1;
  end

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < R);

  if (R > 1) begin : g_single
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);
  end

  assert_valid_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid);

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |=> (zfill == '0));
endmodule

bind cic_interp cic_interp_chk #(.R(R), .W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .zfill    (up_q)
);

// File: tb/sim_cic_interp.sv
`timescale 1ns/1ps
module sim_cic_interp;
  localparam int IN_W = 12;
  localparam int N    = 3;
  localparam int R    = 8;
  localparam int M    = 1;
  localparam int W    = IN_W + cic_pkg::cic_growth(N, R, M);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            in_valid;
  logic [IN_W-1:0] in_data;
  logic            in_ready;
  logic            out_valid;
  logic [W-1:0]    out_data;

  cic_interp #(.IN_W(IN_W), .N(N), .R(R), .M(M)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  longint hist[$];
  longint s[N];
  longint up;
  int     mph;
  bit     mval;

  function automatic longint wrap(input longint v);
    longint r;
    r = v & ((longint'(1) << W) - 1);
    if (r[W-1]) r = r - (longint'(1) << W);
    return r;
  endfunction

  function automatic longint binom(input int n, input int k);
    longint c = 1;
    for (int i = 0; i < k; i++) c = c * (n - i) / (i + 1);
    return c;
  endfunction

  function automatic longint dut_out();
    return longint'($signed(out_data));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    for (int k = 0; k < N; k++) s[k] = 0;
    up = 0; mph = 0; mval = 0;
  endtask

  // called at a falling edge: compare, drive, advance reference, wait a cycle
  task automatic cycle(input bit v, input logic [IN_W-1:0] d);
    longint nu, y, xv;
    chk("R5", dut_out(), wrap(s[N-1]));
    chk("R2", longint'(in_ready), longint'(mph == 0));
    if (mval) chk("R4", longint'(out_valid), 1);
    in_valid = v;
    in_data  = d;
    nu = 0;
    if (mph == 0) begin
      xv = v ? longint'($signed(d)) : 0;
      hist.push_front(xv);
      if (hist.size() > N*M + 1) void'(hist.pop_back());
      y = 0;
      for (int k = 0; k <= N; k++)
        if (k*M < hist.size())
          y += ((k % 2) ? -1 : 1) * binom(N, k) * hist[k*M];
      nu = y;
    end
    for (int k = N-1; k > 0; k--) s[k] = wrap(s[k] + s[k-1]);
    s[0] = wrap(s[0] + up);
    up   = wrap(nu);
    mph  = (mph + 1) % R;
    mval = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", dut_out(), 0);
    chk("R1", longint'(out_valid), 0);
    rst_n = 1'b1;
    model_reset();
    chk("R1", longint'(in_ready), 1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end

  initial begin
    longint gain;
    gain = 1;
    for (int i = 0; i < N; i++) gain = gain * R * M;
    gain = gain / R;

    @(negedge clk);
    do_reset();

    // R8: impulse latency
    cycle(1'b1, IN_W'(1));
    for (int j = 1; j <= N; j++) begin
      chk("R8", dut_out(), 0);
      cycle(1'b0, '0);
    end
    chk("R8", dut_out(), 1);
    for (int j = 0; j < 4*R; j++) cycle(1'b0, '0);

    // R3: garbage offered off the ready phase only
    for (int j = 0; j < 4*R; j++) begin
      chk("R3", dut_out(), 0);
      if (mph == 0) cycle(1'b0, '0);
      else          cycle(1'b1, IN_W'(999));
    end

    // R6: positive constant
    for (int j = 0; j < 20*R; j++) cycle(1'b1, IN_W'(100));
    chk("R6", dut_out(), 100 * gain);

    // R6: negative constant
    for (int j = 0; j < 20*R; j++) cycle(1'b1, IN_W'(-300));
    chk("R6", dut_out(), -300 * gain);

    // R6: full-scale constant
    for (int j = 0; j < 20*R; j++) cycle(1'b1, IN_W'(-2048));
    chk("R6", dut_out(), -2048 * gain);

    // R7: no valid on ready phases behaves as zero samples
    for (int j = 0; j < 20*R; j++) cycle(1'b0, IN_W'(555));
    chk("R7", dut_out(), 0);

    // R7: every other ready phase dropped
    for (int j = 0; j < 16*R; j++) cycle(((j / R) % 2) == 0, IN_W'(700));

    // R5: random stream with random valid
    for (int j = 0; j < 60*R; j++) cycle(1'($urandom), IN_W'($urandom));

    // R1: reset in mid-stream clears all history
    do_reset();
    for (int j = 0; j < 30*R; j++) cycle(1'($urandom), IN_W'($urandom));
    for (int j = 0; j < 20*R; j++) cycle(1'b1, IN_W'(2047));
    chk("R6", dut_out(), 2047 * gain);

    report();
  end
endmodule